// File: doc/BRIEF.md
# Transmit Ring Halt and Frame-Event Status

This block holds the transmit status of eight descriptor rings. Each ring has two sticky flags. The halt flag stops DMA from the ring. The frame-event flag records that a frame from the ring has finished.

A descriptor-fetch front end sends one fetch attempt per cycle. Each attempt carries:
- the ring index;
- the ready bit and length of the fetched descriptor;
- an address-valid flag and a read-error flag;
- a flag that says no ready descriptor was found.

The block checks every attempt for faults. A faulty attempt raises the halt flag of its ring. That ring's DMA enable then falls until software clears the flag.

Software reads the flags on a 16-bit status word. It clears any flag by writing 1 to the same bit position. A graceful-stop request gates every DMA enable while it is asserted. It never touches the halt flags. A registered interrupt line reports whether any flag is set.

Top module: `tx_ring_halt_status`

## Requirements
- R1: The status word is split in two halves. Bit i (0..7) is the halt flag of ring i. Bit 8+i is the frame-event flag of ring i.
- R2: A fetch attempt (`fetch_valid`=1) on ring r sets halt flag r at the next clock edge when any of these holds: `fetch_addr_ok`=0, `fetch_rd_err`=1, or `fetch_ready`=1 with `fetch_len`=0. An attempt with none of these faults sets no flag.
- R3: A fetch attempt with `fetch_none_ready`=1 sets the halt flag of its ring at the next clock edge.
- R4: The halt flag of a ring is set by a fault whatever the value of that ring's `queue_en` bit.
- R5: `gstop_req` never sets a halt flag. While it is 1, every `dma_en` bit is 0.
- R6: `dma_en[r]` equals `queue_en[r] & ~halt[r] & ~gstop_req`, combinationally, from the current halt flags.
- R7: A `frame_done` pulse with index r sets frame-event flag 8+r at the next clock edge.
- R8: A write (`wr_en`=1) clears every status bit whose `wr_data` bit is 1. `wr_data` bits that are 0 leave their flags unchanged. Without a write or a set, flags hold their value.
- R9: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R10: `irq` is a register. After each clock edge it equals the OR of all status bits as they stood before that edge.
- R11: If the fault of a halted ring is still present after software clears the flag, the next faulty fetch attempt sets the flag again.
- R12: A synchronous reset clears all status bits and `irq`. After reset, `dma_en` equals `queue_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch attempt this cycle |
| fetch_ring | input | 3 | Ring index of the attempt |
| fetch_ready | input | 1 | Ready bit of the fetched descriptor |
| fetch_len | input | 16 | Length field of the fetched descriptor |
| fetch_addr_ok | input | 1 | Descriptor and data addresses valid |
| fetch_rd_err | input | 1 | Uncorrectable error on descriptor or data read |
| fetch_none_ready | input | 1 | No ready descriptor found in the ring |
| frame_done | input | 1 | Frame transmit finished |
| frame_ring | input | 3 | Ring index of the finished frame |
| gstop_req | input | 1 | Graceful stop request from the user |
| queue_en | input | 8 | Per-ring queue enable |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 16 | Write-one-to-clear mask |
| dma_en | output | 8 | Per-ring DMA enable |
| status | output | 16 | Halt flags [7:0], frame-event flags [15:8] |
| irq | output | 1 | Registered OR of all status bits |

## Verification
Two things can land on the same flag in the same cycle: a hardware set (a faulty fetch or a frame-done pulse) and a software write-one-to-clear. The bench provokes this on purpose. It drives a zero-length fetch on ring 0 together with a write that clears bit 0. It also drives a frame-done on ring 2 together with a write that clears bit 10. In both cases the flag must read 1 after the edge.

The random phase mixes faults, frame pulses and clear masks freely, so many more such collisions occur. Every collision is judged against a bench model in which the set takes priority.

// File: rtl/txh_pkg.sv
package txh_pkg;
    parameter int unsigned NUM_RINGS = 8;
    parameter int unsigned LEN_W     = 16;
    localparam int unsigned RIDX_W   = $clog2(NUM_RINGS);
    localparam int unsigned STAT_W   = 2 * NUM_RINGS;

    typedef struct packed {
        logic              valid;
        logic [RIDX_W-1:0] ring;
        logic              rdy;
        logic [LEN_W-1:0]  len;
        logic              addr_ok;
        logic              rd_err;
        logic              none_rdy;
    } fetch_t;

    typedef enum logic [2:0] {
        FLT_NONE,
        FLT_EMPTY,
        FLT_ADDR,
        FLT_READ,
        FLT_ZLEN
    } fault_e;

    function automatic fault_e classify(input fetch_t f);
        fault_e c;
        if (!f.valid)                    c = FLT_NONE;
        else if (f.none_rdy)             c = FLT_EMPTY;
        else if (!f.addr_ok)             c = FLT_ADDR;
        else if (f.rd_err)               c = FLT_READ;
        else if (f.rdy && f.len == '0)   c = FLT_ZLEN;
        else                             c = FLT_NONE;
        return c;
    endfunction

    function automatic logic [NUM_RINGS-1:0] ring_onehot(input logic [RIDX_W-1:0] idx,
                                                         input logic en);
        logic [NUM_RINGS-1:0] v;
        v = '0;
        if (en) v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/txh_fault_decode.sv
module txh_fault_decode
    import txh_pkg::*;
(
    input  fetch_t               fetch_i,
    output logic [NUM_RINGS-1:0] halt_set_o
);
    fault_e cause;

    always_comb begin
        cause      = classify(fetch_i);
        halt_set_o = ring_onehot(fetch_i.ring, cause != FLT_NONE);
    end
endmodule

// File: rtl/txh_w1c_bank.sv
module txh_w1c_bank #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else
                flag_q <= set_i[g] | (flag_q & ~clr_i[g]);
        end
        assign q_o[g] = flag_q;
    end
endmodule

// File: rtl/txh_irq_reg.sv
module txh_irq_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] status_i,
    output logic             irq_o
);
    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else
            irq_o <= |status_i;
    end
endmodule

// File: rtl/tx_ring_halt_status.sv
module tx_ring_halt_status
    import txh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fetch_valid,
    input  logic [RIDX_W-1:0]    fetch_ring,
    input  logic                 fetch_ready,
    input  logic [LEN_W-1:0]     fetch_len,
    input  logic                 fetch_addr_ok,
    input  logic                 fetch_rd_err,
    input  logic                 fetch_none_ready,
    input  logic                 frame_done,
    input  logic [RIDX_W-1:0]    frame_ring,
    input  logic                 gstop_req,
    input  logic [NUM_RINGS-1:0] queue_en,
    input  logic                 wr_en,
    input  logic [STAT_W-1:0]    wr_data,
    output logic [NUM_RINGS-1:0] dma_en,
    output logic [STAT_W-1:0]    status,
    output logic                 irq
);
    fetch_t               fq;
    logic [NUM_RINGS-1:0] halt_set, evt_set, halt_clr, evt_clr, halt_q, evt_q;

    assign fq = '{valid: fetch_valid, ring: fetch_ring, rdy: fetch_ready, len: fetch_len,
                  addr_ok: fetch_addr_ok, rd_err: fetch_rd_err, none_rdy: fetch_none_ready};

    txh_fault_decode u_dec (
        .fetch_i   (fq),
        .halt_set_o(halt_set)
    );

    assign evt_set  = ring_onehot(frame_ring, frame_done);
    assign halt_clr = wr_en ? wr_data[NUM_RINGS-1:0]      : '0;
    assign evt_clr  = wr_en ? wr_data[STAT_W-1:NUM_RINGS] : '0;

    txh_w1c_bank #(.WIDTH(NUM_RINGS)) u_halt (
        .clk  (clk),
        .rst  (rst),
        .set_i(halt_set),
        .clr_i(halt_clr),
        .q_o  (halt_q)
    );

    txh_w1c_bank #(.WIDTH(NUM_RINGS)) u_evt (
        .clk  (clk),
        .rst  (rst),
        .set_i(evt_set),
        .clr_i(evt_clr),
        .q_o  (evt_q)
    );

    assign status = {evt_q, halt_q};

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_dma
        assign dma_en[g] = queue_en[g] & ~halt_q[g] & ~gstop_req;
    end

    txh_irq_reg #(.WIDTH(STAT_W)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .status_i(status),
        .irq_o   (irq)
    );
endmodule

// File: rtl/txh_checker.sv
module txh_checker
    import txh_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 fetch_valid,
    input logic [RIDX_W-1:0]    fetch_ring,
    input logic                 fetch_ready,
    input logic [LEN_W-1:0]     fetch_len,
    input logic                 fetch_addr_ok,
    input logic                 fetch_rd_err,
    input logic                 fetch_none_ready,
    input logic                 frame_done,
    input logic [RIDX_W-1:0]    frame_ring,
    input logic                 gstop_req,
    input logic [NUM_RINGS-1:0] queue_en,
    input logic                 wr_en,
    input logic [STAT_W-1:0]    wr_data,
    input logic [NUM_RINGS-1:0] dma_en,
    input logic [STAT_W-1:0]    status,
    input logic                 irq
);
    AST_ZLEN_HALTS: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && fetch_ready && fetch_len == '0 |=> status[$past(fetch_ring)]); // R2

    AST_EMPTY_HALTS: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && fetch_none_ready |=> status[$past(fetch_ring)]); // R3

    AST_HALT_GATES_DMA: assert property (@(posedge clk) disable iff (rst)
        (status[NUM_RINGS-1:0] & dma_en) == '0); // R6

    AST_GSTOP_NO_HALT: assert property (@(posedge clk) disable iff (rst)
        gstop_req && !fetch_valid && !wr_en
        |=> status[NUM_RINGS-1:0] == $past(status[NUM_RINGS-1:0])); // R5

    AST_FRAME_SETS: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> status[NUM_RINGS + 32'($past(frame_ring))]); // R7

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (status & $past(status)) == $past(status)); // R8

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past(|status)); // R10
endmodule

bind tx_ring_halt_status txh_checker i_chk (.*);

// File: tb/test_tx_ring_halt_status.sv
module test_tx_ring_halt_status;
    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_valid, fetch_ready, fetch_addr_ok, fetch_rd_err, fetch_none_ready;
    logic [2:0]  fetch_ring, frame_ring;
    logic [15:0] fetch_len;
    logic        frame_done, gstop_req, wr_en;
    logic [7:0]  queue_en;
    logic [15:0] wr_data;
    logic [7:0]  dma_en;
    logic [15:0] status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_stat;
    logic        m_irq;

    always #4 clk = ~clk;

    tx_ring_halt_status i_tx_ring_halt_status (.*);

    function automatic bit is_fault();
        if (!fetch_valid) return 1'b0;
        return fetch_none_ready || !fetch_addr_ok || fetch_rd_err ||
               (fetch_ready && fetch_len == 16'd0);
    endfunction

    function automatic logic [15:0] next_model();
        logic [15:0] s, clr;
        clr = wr_en ? wr_data : 16'h0;
        s = m_stat & ~clr;
        if (is_fault()) s[fetch_ring] = 1'b1;
        if (frame_done) s[8 + fetch_idx(frame_ring)] = 1'b1;
        return s;
    endfunction

    function automatic int fetch_idx(input logic [2:0] r);
        return int'(r);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        fetch_valid = 0; fetch_ring = 0; fetch_ready = 0; fetch_len = 16'd1;
        fetch_addr_ok = 1; fetch_rd_err = 0; fetch_none_ready = 0;
        frame_done = 0; frame_ring = 0; wr_en = 0; wr_data = 0;
    endtask

    // inputs are set by the caller just after a falling edge
    task automatic step(input string tag);
        logic [15:0] nxt;
        logic        nirq;
        #1;
        chk("R6 dma_en", {24'h0, dma_en}, {24'h0, queue_en & ~m_stat[7:0] & {8{~gstop_req}}});
        nxt  = next_model();
        nirq = |m_stat;
        @(posedge clk);
        @(negedge clk);
        m_stat = nxt;
        m_irq  = nirq;
        chk(tag, {16'h0, status}, {16'h0, m_stat});
        chk("R10 irq", {31'h0, irq}, {31'h0, m_irq});
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        gstop_req = 0; queue_en = 8'hFF; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        m_stat = 0; m_irq = 0;
        chk("R12 status after reset", {16'h0, status}, 32'h0);
        chk("R12 irq after reset", {31'h0, irq}, 32'h0);
        #1 chk("R12 dma_en after reset", {24'h0, dma_en}, 32'hFF);

        // R2 zero length on ring 3
        fetch_valid = 1; fetch_ring = 3; fetch_ready = 1; fetch_len = 0; step("R2 zero-length halt");
        // R4 bad address on disabled ring 5
        queue_en = 8'hDF;
        fetch_valid = 1; fetch_ring = 5; fetch_addr_ok = 0; step("R4 halt with queue off");
        queue_en = 8'hFF;
        // R2 read error on ring 0
        fetch_valid = 1; fetch_ring = 0; fetch_rd_err = 1; step("R2 read-error halt");
        // R3 nothing ready on ring 7
        fetch_valid = 1; fetch_ring = 7; fetch_none_ready = 1; step("R3 empty-ring halt");
        // R2 healthy descriptor sets nothing
        fetch_valid = 1; fetch_ring = 1; fetch_ready = 1; fetch_len = 16'd64; step("R2 good fetch no halt");
        // R5 graceful stop
        gstop_req = 1; step("R5 gstop no halt");
        gstop_req = 1; step("R5 gstop held");
        gstop_req = 0;
        // R8 writing zeros, then clearing bit 3
        wr_en = 1; wr_data = 16'h0000; step("R8 write zero no effect");
        wr_en = 1; wr_data = 16'h0008; step("R8 clear ring 3");
        chk("R8 ring 3 cleared", {31'h0, status[3]}, 32'h0);
        // R11 same fault again after the clear
        fetch_valid = 1; fetch_ring = 3; fetch_ready = 1; fetch_len = 0; step("R11 repeat fault");
        chk("R11 ring 3 halted again", {31'h0, status[3]}, 32'h1);
        // R7 frame event ring 2
        frame_done = 1; frame_ring = 2; step("R7 frame event");
        chk("R1 event ring 2 at bit 10", {31'h0, status[10]}, 32'h1);
        // R9 set vs clear collisions
        frame_done = 1; frame_ring = 2; wr_en = 1; wr_data = 16'h0400; step("R9 event set wins");
        fetch_valid = 1; fetch_ring = 0; fetch_ready = 1; fetch_len = 0;
        wr_en = 1; wr_data = 16'h0001; step("R9 halt set wins");
        chk("R9 ring 0 still halted", {31'h0, status[0]}, 32'h1);
        wr_en = 1; wr_data = 16'hFFFF; step("R8 clear all");
        step("R10 irq drops after clear");

        for (int i = 0; i < 600; i++) begin
            fetch_valid      = ($urandom % 3) == 0;
            fetch_ring       = 3'($urandom);
            fetch_ready      = ($urandom % 4) != 0;
            fetch_len        = (($urandom % 4) == 0) ? 16'd0 : 16'($urandom);
            fetch_addr_ok    = ($urandom % 8) != 0;
            fetch_rd_err     = ($urandom % 8) == 0;
            fetch_none_ready = ($urandom % 8) == 0;
            frame_done       = ($urandom % 3) == 0;
            frame_ring       = 3'($urandom);
            gstop_req        = ($urandom % 10) == 0;
            queue_en         = 8'($urandom);
            wr_en            = ($urandom % 3) == 0;
            wr_data          = 16'($urandom);
            step("R2/R7 random status");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule